// File: doc/BRIEF.md
# Four-Phase Pulse-Width Bit Codec

This block sends and receives single bits on a one-wire serial line where each bit is timed on its own. A bit is a fixed run of four phases. A preparation phase sits at the idle level. A sync phase follows at the opposite level. Then comes a data phase whose level is the bit value. A halt phase returns the line to idle. The transmit side takes a bit and a start strobe and drives the whole sequence. The receive side watches the line and locks onto the preparation-to-sync edge of every bit. It samples the middle of the data phase and reports either a decoded bit or a framing error.

Two timing sets, one for the master role and one for the slave role, are fixed by parameters in system-clock cycles. A role input picks the set, and the set is captured when a bit begins. A polarity input inverts every level, both on the transmit drive and in the receiver's reading of the line. Multi-bit framing, addressing and arbitration belong to the logic around this block.

Top module: `pwbit_codec`

## Requirements
- R1: With `active_low_i`=0, a transmitted bit drives the line high for the preparation length, then low for the sync length, then at the bit value (high=1, low=0) for the data length, then high for the halt length. The first preparation cycle is the cycle right after the clock edge that accepts the start.
- R2: With `active_low_i`=1, every transmitted level is inverted, and the receiver reads a low line as logical 1.
- R3: While no bit is being sent, the transmitter holds the line at the idle level (high when `active_low_i`=0). A synchronous reset, even in the middle of a bit, returns the line to idle and clears `tx_busy_o`, `tx_done_o`, `rx_valid_o` and `rx_err_o`.
- R4: `tx_done_o` is high for exactly one cycle. That cycle comes prep+sync+data+halt cycles after the accepting edge. A start presented in that cycle is accepted, so bits can be sent back to back.
- R5: A start strobe that arrives while `tx_busy_o` is high is ignored, and the bit in progress continues unchanged.
- R6: `role_i`=0 selects the master lengths and `role_i`=1 selects the slave lengths. The transmitter captures the choice when it accepts a start, and the receiver captures it when it detects a sync edge.
- R7: The receiver passes the line through a two-flop synchronizer and samples it at sync + data/2 cycles after the detected sync edge. If the halt level is correct at the last halt cycle, it raises `rx_valid_o` for one cycle with the sampled bit on `rx_bit_o`.
- R8: If the line goes back to the idle level within the first sync/2 cycles after a sync edge, `rx_err_o` pulses for one cycle and no valid is given for that bit.
- R9: If the line is not at the idle level in the last cycle of the halt window, `rx_err_o` pulses for one cycle and no valid is given.
- R10: The receiver re-aligns on every bit, so back-to-back bits each give their own valid with the correct value. `rx_valid_o` and `rx_err_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| role_i | input | 1 | Timing set select: 0 master, 1 slave |
| active_low_i | input | 1 | Line polarity: 1 inverts all levels |
| tx_start_i | input | 1 | Start strobe for one transmitted bit |
| tx_bit_i | input | 1 | Bit value to transmit, taken with the start |
| tx_busy_o | output | 1 | A bit is being transmitted |
| tx_done_o | output | 1 | One-cycle pulse after the halt phase ends |
| tx_line_o | output | 1 | Registered line drive |
| rx_line_i | input | 1 | Raw line level seen by the receiver |
| rx_valid_o | output | 1 | One-cycle pulse: a bit was decoded |
| rx_bit_o | output | 1 | Decoded bit value, held after valid |
| rx_err_o | output | 1 | One-cycle framing error pulse |

## Verification
The assertions assume that `active_low_i` changes only while reset is asserted. The idle-level property compares the line with the current polarity, so a polarity change while running would break it. The bench therefore sets polarity and role, and then pulses reset before each vector. The assertions also assume that every phase length is at least one cycle and that the sync length is at least four, so the sync/2 glitch window is not empty. The bench's parameters keep to this. Glitches and halt faults are driven on the receive line directly, with the loopback switched off, so the transmitter never sees malformed stimulus.

// File: rtl/pwbit_pkg.sv
package pwbit_pkg;
  localparam int CNT_W = 8;
  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [CNT_W+1:0] pos_t;

  typedef struct packed {
    cnt_t prep;
    cnt_t sync;
    cnt_t data;
    cnt_t halt;
  } phase_len_t;

  typedef enum logic [2:0] {
    TX_IDLE, TX_PREP, TX_SYNC, TX_DATA, TX_HALT
  } tx_state_e;

  typedef enum logic [1:0] {
    RX_WAIT, RX_ARM, RX_BIT
  } rx_state_e;
endpackage

// File: rtl/pwbit_timing.sv
module pwbit_timing
  import pwbit_pkg::*;
#(
  parameter int M_PREP = 4,
  parameter int M_SYNC = 6,
  parameter int M_DATA = 6,
  parameter int M_HALT = 4,
  parameter int S_PREP = 3,
  parameter int S_SYNC = 4,
  parameter int S_DATA = 4,
  parameter int S_HALT = 3
) (
  input  logic       role_i,
  output phase_len_t len_o
);
  localparam phase_len_t MASTER_LEN = '{prep: cnt_t'(M_PREP), sync: cnt_t'(M_SYNC),
                                        data: cnt_t'(M_DATA), halt: cnt_t'(M_HALT)};
  localparam phase_len_t SLAVE_LEN  = '{prep: cnt_t'(S_PREP), sync: cnt_t'(S_SYNC),
                                        data: cnt_t'(S_DATA), halt: cnt_t'(S_HALT)};

  always_comb begin
    len_o = role_i ? SLAVE_LEN : MASTER_LEN;
  end
endmodule

// File: rtl/pwbit_sync.sv
module pwbit_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwbit_tx.sv
module pwbit_tx
  import pwbit_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       active_low_i,
  input  logic       start_i,
  input  logic       bit_i,
  input  phase_len_t len_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       line_o
);
  tx_state_e  state_q, state_n;
  cnt_t       cnt_q, cnt_n;
  phase_len_t len_q, len_n;
  logic       bit_q, bit_n;
  logic       done_n;
  logic       level_n;
  logic       last_cyc;

  assign last_cyc = (cnt_q == '0);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    len_n   = len_q;
    bit_n   = bit_q;
    done_n  = 1'b0;
    case (state_q)
      TX_IDLE: begin
        if (start_i) begin
          state_n = TX_PREP;
          cnt_n   = len_i.prep - cnt_t'(1);
          len_n   = len_i;
          bit_n   = bit_i;
        end
      end
      TX_PREP: begin
        if (last_cyc) begin
          state_n = TX_SYNC;
          cnt_n   = len_q.sync - cnt_t'(1);
        end else begin
          cnt_n = cnt_q - cnt_t'(1);
        end
      end
      TX_SYNC: begin
        if (last_cyc) begin
          state_n = TX_DATA;
          cnt_n   = len_q.data - cnt_t'(1);
        end else begin
          cnt_n = cnt_q - cnt_t'(1);
        end
      end
      TX_DATA: begin
        if (last_cyc) begin
          state_n = TX_HALT;
          cnt_n   = len_q.halt - cnt_t'(1);
        end else begin
          cnt_n = cnt_q - cnt_t'(1);
        end
      end
      TX_HALT: begin
        if (last_cyc) begin
          state_n = TX_IDLE;
          done_n  = 1'b1;
        end else begin
          cnt_n = cnt_q - cnt_t'(1);
        end
      end
      default: state_n = TX_IDLE;
    endcase
  end

  always_comb begin
    case (state_n)
      TX_SYNC: level_n = 1'b0;
      TX_DATA: level_n = bit_n;
      default: level_n = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
      bit_q   <= 1'b0;
      done_o  <= 1'b0;
      line_o  <= ~active_low_i;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      len_q   <= len_n;
      bit_q   <= bit_n;
      done_o  <= done_n;
      line_o  <= level_n ^ active_low_i;
    end
  end

  assign busy_o = (state_q != TX_IDLE);
endmodule

// File: rtl/pwbit_rx.sv
module pwbit_rx
  import pwbit_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       active_low_i,
  input  logic       line_i,
  input  phase_len_t len_i,
  output logic       valid_o,
  output logic       bit_o,
  output logic       err_o
);
  logic       line_s;
  logic       lvl;
  logic       prev_q;
  rx_state_e  state_q;
  pos_t       pos_q;
  phase_len_t len_q;
  logic       samp_q;
  pos_t       half_sync, mid_data, last_halt;

  pwbit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (line_i),
    .q_o (line_s)
  );

  assign lvl       = line_s ^ active_low_i;
  assign half_sync = pos_t'(len_q.sync >> 1);
  assign mid_data  = pos_t'(len_q.sync) + pos_t'(len_q.data >> 1);
  assign last_halt = pos_t'(len_q.sync) + pos_t'(len_q.data) + pos_t'(len_q.halt) - pos_t'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RX_WAIT;
      pos_q   <= '0;
      len_q   <= '0;
      samp_q  <= 1'b0;
      prev_q  <= 1'b0;
      valid_o <= 1'b0;
      bit_o   <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      prev_q  <= lvl;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      case (state_q)
        RX_WAIT: begin
          if (lvl) state_q <= RX_ARM;
        end
        RX_ARM: begin
          if (prev_q && !lvl) begin
            state_q <= RX_BIT;
            pos_q   <= pos_t'(1);
            len_q   <= len_i;
          end
        end
        RX_BIT: begin
          pos_q <= pos_q + pos_t'(1);
          if (pos_q < half_sync && lvl) begin
            err_o   <= 1'b1;
            state_q <= RX_WAIT;
          end else if (pos_q == last_halt) begin
            if (lvl) begin
              valid_o <= 1'b1;
              bit_o   <= samp_q;
              state_q <= RX_ARM;
            end else begin
              err_o   <= 1'b1;
              state_q <= RX_WAIT;
            end
          end else if (pos_q == mid_data) begin
            samp_q <= lvl;
          end
        end
        default: state_q <= RX_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/pwbit_codec.sv
module pwbit_codec
  import pwbit_pkg::*;
#(
  parameter int M_PREP      = 4,
  parameter int M_SYNC      = 6,
  parameter int M_DATA      = 6,
  parameter int M_HALT      = 4,
  parameter int S_PREP      = 3,
  parameter int S_SYNC      = 4,
  parameter int S_DATA      = 4,
  parameter int S_HALT      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic role_i,
  input  logic active_low_i,
  input  logic tx_start_i,
  input  logic tx_bit_i,
  output logic tx_busy_o,
  output logic tx_done_o,
  output logic tx_line_o,
  input  logic rx_line_i,
  output logic rx_valid_o,
  output logic rx_bit_o,
  output logic rx_err_o
);
  phase_len_t len_sel;

  pwbit_timing #(
    .M_PREP(M_PREP), .M_SYNC(M_SYNC), .M_DATA(M_DATA), .M_HALT(M_HALT),
    .S_PREP(S_PREP), .S_SYNC(S_SYNC), .S_DATA(S_DATA), .S_HALT(S_HALT)
  ) u_timing (
    .role_i (role_i),
    .len_o  (len_sel)
  );

  pwbit_tx u_tx (
    .clk          (clk),
    .rst          (rst),
    .active_low_i (active_low_i),
    .start_i      (tx_start_i),
    .bit_i        (tx_bit_i),
    .len_i        (len_sel),
    .busy_o       (tx_busy_o),
    .done_o       (tx_done_o),
    .line_o       (tx_line_o)
  );

  pwbit_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk          (clk),
    .rst          (rst),
    .active_low_i (active_low_i),
    .line_i       (rx_line_i),
    .len_i        (len_sel),
    .valid_o      (rx_valid_o),
    .bit_o        (rx_bit_o),
    .err_o        (rx_err_o)
  );
endmodule

// File: rtl/pwbit_codec_chk.sv
module pwbit_codec_chk (
  input logic clk,
  input logic rst,
  input logic active_low_i,
  input logic tx_start_i,
  input logic tx_busy_o,
  input logic tx_done_o,
  input logic tx_line_o,
  input logic rx_valid_o,
  input logic rx_err_o
);
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !tx_busy_o |-> (tx_line_o == !active_low_i)); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    tx_done_o |=> !tx_done_o); // R4
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    tx_done_o |-> !tx_busy_o); // R4
  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_busy_o) |-> $past(tx_start_i)); // R5
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_valid_o |=> !rx_valid_o); // R7
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rx_err_o |=> !rx_err_o); // R8
  AST_VALID_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid_o && rx_err_o)); // R10
endmodule

bind pwbit_codec pwbit_codec_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .active_low_i (active_low_i),
  .tx_start_i   (tx_start_i),
  .tx_busy_o    (tx_busy_o),
  .tx_done_o    (tx_done_o),
  .tx_line_o    (tx_line_o),
  .rx_valid_o   (rx_valid_o),
  .rx_err_o     (rx_err_o)
);

// File: tb/sim_pwbit_codec.sv
`timescale 1ns/1ps
module sim_pwbit_codec;
  localparam int MP = 4, MS = 6, MD = 6, MH = 4;
  localparam int SP = 3, SS = 4, SD = 4, SH = 3;
  localparam int NVEC = 8;
  // each entry: {role, active_low, bit}
  localparam logic [2:0] VEC [NVEC] = '{3'b001, 3'b000, 3'b011, 3'b010,
                                        3'b101, 3'b100, 3'b111, 3'b110};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic role = 1'b0, pol = 1'b0, start = 1'b0, txb = 1'b0;
  logic manual = 1'b0, man_lvl = 1'b1;
  logic busy, done, line, valid, rbit, rerr, rx_in;
  int checks = 0, errors = 0;
  int nvalid = 0, nerr = 0;
  logic [7:0] bits_seen = '0;
  int cyc = 0;

  always #2 clk = ~clk;

  assign rx_in = manual ? man_lvl : line;

  pwbit_codec #(
    .M_PREP(MP), .M_SYNC(MS), .M_DATA(MD), .M_HALT(MH),
    .S_PREP(SP), .S_SYNC(SS), .S_DATA(SD), .S_HALT(SH), .SYNC_STAGES(2)
  ) u0 (
    .clk(clk), .rst(rst), .role_i(role), .active_low_i(pol),
    .tx_start_i(start), .tx_bit_i(txb), .tx_busy_o(busy), .tx_done_o(done),
    .tx_line_o(line), .rx_line_i(rx_in), .rx_valid_o(valid), .rx_bit_o(rbit),
    .rx_err_o(rerr)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (valid) begin
        nvalid = nvalid + 1;
        bits_seen = {bits_seen[6:0], rbit};
      end
      if (rerr) nerr = nerr + 1;
    end
  end

  task automatic summary_and_end();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 50000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, 50000);
      summary_and_end();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    nvalid = 0; nerr = 0; bits_seen = '0;
  endtask

  task automatic do_reset(input logic r, input logic p);
    @(negedge clk);
    role = r; pol = p; rst = 1'b1; manual = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    clear_mon();
  endtask

  // Called at a negedge. Returns at the negedge of the done cycle.
  task automatic send_bit(input logic r, input logic b, input bit poke, input string req);
    int p, s, d, h, l, bad, exp_l, act_l;
    p = r ? SP : MP; s = r ? SS : MS; d = r ? SD : MD; h = r ? SH : MH;
    l = p + s + d + h;
    bad = 0; exp_l = 0; act_l = 0;
    role = r; txb = b; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    for (int c = 0; c <= l; c++) begin
      @(negedge clk);
      if (c < l) begin
        int lg;
        if (c < p) lg = 1;
        else if (c < p + s) lg = 0;
        else if (c < p + s + d) lg = b;
        else lg = 1;
        if (line !== (1'(lg) ^ pol) || done !== 1'b0 || busy !== 1'b1) begin
          if (bad == 0) begin exp_l = 1'(lg) ^ pol; act_l = line; end
          bad++;
        end
        if (poke && c == 4) begin start = 1'b1; txb = ~b; end
        if (poke && c == 5) begin start = 1'b0; txb = b; end
      end else begin
        chk(done === 1'b1 && busy === 1'b0, "R4 done pulse at end of halt", done, 1);
      end
    end
    chk(bad == 0, req, act_l, exp_l);
  endtask

  task automatic drive(input logic lv, input int n);
    man_lvl = lv;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R3: reset state
    repeat (3) @(negedge clk);
    chk(line === 1'b1 && busy === 1'b0 && done === 1'b0 && valid === 1'b0 && rerr === 1'b0,
        "R3 reset state", {line, busy, done, valid, rerr}, 5'b10000);

    // table walk: waveform, polarity, role and loopback decode
    for (int v = 0; v < NVEC; v++) begin
      logic vr, vp, vb;
      {vr, vp, vb} = VEC[v];
      do_reset(vr, vp);
      chk(line === ~vp, "R3 idle level after reset", line, ~vp);
      send_bit(vr, vb, 1'b0, vp ? "R2 inverted waveform" : (vr ? "R6 slave waveform" : "R1 master waveform"));
      repeat (10) @(negedge clk);
      chk(nvalid == 1 && nerr == 0 && bits_seen[0] == vb, "R7 loopback decode",
          {nvalid[3:0], bits_seen[0]}, {4'd1, vb});
    end

    // R5: start while busy is ignored
    do_reset(1'b0, 1'b0);
    send_bit(1'b0, 1'b1, 1'b1, "R5 busy start ignored, waveform");
    repeat (30) @(negedge clk);
    chk(busy === 1'b0 && nvalid == 1 && bits_seen[0] == 1'b1, "R5 no extra bit",
        nvalid, 1);

    // R4 and R10: back-to-back bits, start taken in done cycle
    do_reset(1'b0, 1'b1);
    send_bit(1'b0, 1'b1, 1'b0, "R4 first chained bit");
    send_bit(1'b0, 1'b0, 1'b0, "R4 second chained bit in done cycle");
    send_bit(1'b0, 1'b1, 1'b0, "R4 third chained bit");
    repeat (10) @(negedge clk);
    chk(nvalid == 3 && nerr == 0 && bits_seen[2:0] == 3'b101, "R10 per-bit realign",
        {nvalid[3:0], bits_seen[2:0]}, {4'd3, 3'b101});

    // R8: sync glitch shorter than sync/2
    do_reset(1'b0, 1'b0);
    manual = 1'b1;
    drive(1'b1, 8); drive(1'b0, 1); drive(1'b1, 14);
    chk(nerr == 1 && nvalid == 0, "R8 short sync error", {nerr[3:0], nvalid[3:0]}, 8'h10);

    // R9: halt level wrong
    clear_mon();
    drive(1'b1, 8); drive(1'b0, MS); drive(1'b1, MD); drive(1'b0, MH); drive(1'b1, 14);
    chk(nerr == 1 && nvalid == 0, "R9 halt error", {nerr[3:0], nvalid[3:0]}, 8'h10);

    // R7: clean manual bit 0 after errors
    clear_mon();
    drive(1'b1, 8); drive(1'b0, MS); drive(1'b0, MD); drive(1'b1, MH); drive(1'b1, 12);
    chk(nvalid == 1 && nerr == 0 && bits_seen[0] == 1'b0, "R7 manual zero decode",
        {nvalid[3:0], bits_seen[0]}, {4'd1, 1'b0});

    // R2: receiver inversion with manual drive
    do_reset(1'b0, 1'b1);
    manual = 1'b1; clear_mon();
    drive(1'b0, 8); drive(1'b1, MS); drive(1'b0, MD); drive(1'b0, MH); drive(1'b0, 12);
    chk(nvalid == 1 && bits_seen[0] == 1'b1, "R2 receiver inversion",
        {nvalid[3:0], bits_seen[0]}, {4'd1, 1'b1});

    // R3: reset in mid-bit
    do_reset(1'b0, 1'b0);
    @(negedge clk); txb = 1'b0; start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(line === 1'b1 && busy === 1'b0 && done === 1'b0, "R3 mid-bit reset",
        {line, busy, done}, 3'b100);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    summary_and_end();
  end
endmodule